// File: doc/BRIEF.md
# Serial EEPROM Read-Side Target

This block is the read side of a two-wire serial EEPROM target. It watches the SCL and SDA lines, which are already synchronized to the system clock. It recognizes Start and Stop conditions and decodes the select byte that follows each Start. It answers by pulling SDA low, either for an acknowledge or for a zero data bit.

The block holds two stores:

- a main array of 256 bytes;
- an identification page of 16 bytes.

One address counter serves both stores. A write-direction select followed by an address byte loads the counter. A repeated Start and a read select then stream bytes out from that point. The counter advances after each byte sent.

A lock-status query is a write-direction select to the identification page, then an address byte, then one data byte. The block acknowledges the data byte only when the page is unlocked. It never stores that data byte. A Start that follows the query cancels it.

The arrays are filled through a plain load port before any bus traffic.

Top module: `eeprom_rd_target`

## Requirements
- R1: A synchronous active-low reset releases SDA (`sda_pull_low` = 0) and clears the address counter to 00h.
- R2: The select byte is laid out as follows: bits [7:4] are the type (1010b for the array, 1011b for the page), bits [3:1] must equal `chip_sel`, and bit 0 is the direction (1 means read). A select that does not match is not acknowledged, and the block stays silent until the next Start.
- R3: An array write select followed by an address byte acknowledges both bytes and loads the counter with the full address. A repeated Start and an array read select then return the byte at that address.
- R4: A read select sent without an address phase returns the byte at the counter, then advances the counter. The counter is shared, so it keeps the value left by the last page access.
- R5: The block keeps sending bytes while the master acknowledges each one. After a byte the master does not acknowledge, followed by a Stop, SDA stays released.
- R6: Array reads advance the counter from FFh to 00h and keep streaming from there.
- R7: For page accesses, the address byte is acknowledged only when bit 7 is 0. Bits 6..4 are ignored, and the counter is loaded with bits 3..0 with the upper bits zero. An address byte with bit 7 set is not acknowledged and does not change the counter.
- R8: Page reads advance only the low 4 counter bits, so the offset goes from Fh back to 0h without ever reaching the array.
- R9: The data byte of a lock-status query is acknowledged when `id_lock` = 0 and not acknowledged when `id_lock` = 1. Page contents are unchanged either way.
- R10: A Start or Stop is recognized only when SDA changes while SCL is high. `sda_pull_low` changes only in a cycle after SCL was low. A Start after a query cancels it.
- R11: Data bytes leave MSB first, one bit per SCL low phase.
- R12: A data byte after an array write select and address is not acknowledged.
- R13: While `pre_we` = 1, `pre_data` is written at `pre_addr`: into the array when `pre_id` = 0, or into the page at `pre_addr[3:0]` when `pre_id` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Synchronized SCL line |
| sda_in | input | 1 | Synchronized SDA line (wired-AND value) |
| sda_pull_low | output | 1 | 1 pulls SDA low |
| chip_sel | input | 3 | Strapped chip-select bits matched against select bits [3:1] |
| id_lock | input | 1 | 1 marks the identification page as locked |
| pre_we | input | 1 | Load strobe for the stores |
| pre_id | input | 1 | Load target: 0 array, 1 page |
| pre_addr | input | 8 | Load address |
| pre_data | input | 8 | Load data |

## Verification
A wrong counter value appears as a wrong data byte in the very next read transfer. The counter is shared, so a page access that left a bad value is exposed by the next select-only array read. A wrong decode or acknowledge decision appears in the ninth SCL high phase of the byte concerned: SDA is high where low was expected, or the reverse. A control path that is stuck in a state shows up either as SDA still held low after a Stop, or as missing bits in the next byte.

// File: rtl/eeprom_rd_pkg.sv
// Shared types and constants for the serial EEPROM read-side target.
// Assumes byte-wide bus transfers of fixed size.
package eeprom_rd_pkg;
    localparam int BYTE_W = 8;
    localparam int BCW    = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,  // silent until a Start
        ST_RX,    // shifting a byte in from the master
        ST_ACK,   // ninth clock after a received byte
        ST_TX,    // shifting a byte out to the master
        ST_MACK   // ninth clock after a sent byte (master answers)
    } bus_st_t;

    typedef enum logic [1:0] {
        PH_SEL,
        PH_ADDR,
        PH_DATA
    } bus_ph_t;
endpackage

// File: rtl/ee_line_events.sv
// Detects SCL edges and Start/Stop conditions on pre-synchronized lines.
// Assumes both inputs already share the clk domain.
module ee_line_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_q;
    logic sda_q;

    // Keep one-cycle history of both lines (idle bus reads high).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    assign scl_rise = scl && !scl_q;
    assign scl_fall = !scl && scl_q;
    assign start_ev = scl && scl_q && sda_q && !sda;
    assign stop_ev  = scl && scl_q && !sda_q && sda;
endmodule

// File: rtl/ee_byte_store.sv
// Main byte array and identification page as register files.
// Asynchronous read, synchronous load from the preload port.
module ee_byte_store #(
    parameter int AW = 8,
    parameter int IW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          ld_en,
    input  logic          ld_page,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    input  logic [AW-1:0] mem_raddr,
    input  logic [IW-1:0] page_raddr,
    output logic [DW-1:0] mem_q,
    output logic [DW-1:0] page_q
);
    localparam int MEM_DEPTH  = 1 << AW;
    localparam int PAGE_DEPTH = 1 << IW;

    logic [DW-1:0] mem  [MEM_DEPTH];
    logic [DW-1:0] page [PAGE_DEPTH];

    // Preload writes into the selected store.
    always_ff @(posedge clk) begin
        if (ld_en && !ld_page) mem[ld_addr] <= ld_data;
        if (ld_en && ld_page)  page[ld_addr[IW-1:0]] <= ld_data;
    end

    assign mem_q  = mem[mem_raddr];
    assign page_q = page[page_raddr];
endmodule

// File: rtl/ee_addr_counter.sv
// Shared address counter: load, full-width step, or narrow step that
// wraps only the low IW bits. Load wins over step.
module ee_addr_counter #(
    parameter int AW = 8,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    input  logic          narrow,
    output logic [AW-1:0] cnt
);
    // Update the counter from load or step requests.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (step && narrow)
            cnt <= {cnt[AW-1:IW], cnt[IW-1:0] + 1'b1};
        else if (step)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/eeprom_rd_target.sv
// Read-side two-wire EEPROM target. Decodes the select byte, runs the
// address phase, streams bytes out and answers lock-status queries.
// Assumes synchronized SCL/SDA, no clock stretching, and bit times much
// longer than clk.
module eeprom_rd_target
    import eeprom_rd_pkg::*;
#(
    parameter int         MEM_AW   = 8,
    parameter int         ID_AW    = 4,
    parameter int         CE_W     = 3,
    parameter logic [3:0] MEM_TYPE = 4'b1010,
    parameter logic [3:0] ID_TYPE  = 4'b1011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull_low,
    input  logic [CE_W-1:0]   chip_sel,
    input  logic              id_lock,
    input  logic              pre_we,
    input  logic              pre_id,
    input  logic [MEM_AW-1:0] pre_addr,
    input  logic [BYTE_W-1:0] pre_data
);
    localparam int TYPE_LSB = CE_W + 1;

    logic scl_rise, scl_fall, start_ev, stop_ev;
    bus_st_t state;
    bus_ph_t phase;
    logic [BCW-1:0]    bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txb;
    logic is_rd, sp_id, acked, more;
    logic ack_ok, byte_done;
    logic [MEM_AW-1:0] addr_cnt;
    logic [MEM_AW-1:0] cnt_load_val;
    logic cnt_load, cnt_step;
    logic [BYTE_W-1:0] mem_q, page_q, rd_byte;

    ee_line_events u_ev (
        .clk(clk), .rst_n(rst_n), .scl(scl_in), .sda(sda_in),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    ee_byte_store #(.AW(MEM_AW), .IW(ID_AW), .DW(BYTE_W)) u_store (
        .clk(clk), .ld_en(pre_we), .ld_page(pre_id), .ld_addr(pre_addr),
        .ld_data(pre_data), .mem_raddr(addr_cnt),
        .page_raddr(addr_cnt[ID_AW-1:0]), .mem_q(mem_q), .page_q(page_q)
    );

    ee_addr_counter #(.AW(MEM_AW), .IW(ID_AW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_load_val),
        .step(cnt_step), .narrow(sp_id), .cnt(addr_cnt)
    );

    // Decide whether the byte just received earns an acknowledge.
    always_comb begin
        unique case (phase)
            PH_SEL:  ack_ok = ((shreg[BYTE_W-1:TYPE_LSB] == MEM_TYPE) ||
                               (shreg[BYTE_W-1:TYPE_LSB] == ID_TYPE)) &&
                              (shreg[TYPE_LSB-1:1] == chip_sel);
            PH_ADDR: ack_ok = sp_id ? !shreg[BYTE_W-1] : 1'b1;
            default: ack_ok = sp_id && !id_lock;
        endcase
    end

    assign byte_done    = (state == ST_RX) && scl_fall && (bitcnt == BCW'(BYTE_W));
    assign cnt_load     = byte_done && (phase == PH_ADDR) && ack_ok;
    assign cnt_load_val = sp_id ? {{(MEM_AW-ID_AW){1'b0}}, shreg[ID_AW-1:0]}
                                : shreg[MEM_AW-1:0];
    assign cnt_step     = ((state == ST_ACK) && scl_fall && acked &&
                           (phase == PH_SEL) && is_rd) ||
                          ((state == ST_MACK) && scl_fall && more);
    assign rd_byte      = sp_id ? page_q : mem_q;

    // Bus protocol sequencer and SDA driver.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            phase        <= PH_SEL;
            bitcnt       <= '0;
            shreg        <= '0;
            txb          <= '0;
            is_rd        <= 1'b0;
            sp_id        <= 1'b0;
            acked        <= 1'b0;
            more         <= 1'b0;
            sda_pull_low <= 1'b0;
        end else if (start_ev) begin
            state        <= ST_RX;
            phase        <= PH_SEL;
            bitcnt       <= '0;
            sda_pull_low <= 1'b0;
        end else if (stop_ev) begin
            state        <= ST_IDLE;
            sda_pull_low <= 1'b0;
        end else begin
            unique case (state)
                ST_RX: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[BYTE_W-2:0], sda_in};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_done) begin
                        state        <= ST_ACK;
                        sda_pull_low <= ack_ok;
                        acked        <= ack_ok;
                        bitcnt       <= '0;
                        if (phase == PH_SEL) begin
                            is_rd <= shreg[0];
                            sp_id <= (shreg[BYTE_W-1:TYPE_LSB] == ID_TYPE);
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        sda_pull_low <= 1'b0;
                        if (!acked) begin
                            state <= ST_IDLE;
                        end else if (phase == PH_SEL && is_rd) begin
                            state        <= ST_TX;
                            txb          <= rd_byte;
                            sda_pull_low <= !rd_byte[BYTE_W-1];
                        end else if (phase == PH_SEL) begin
                            phase <= PH_ADDR;
                            state <= ST_RX;
                        end else if (phase == PH_ADDR) begin
                            phase <= PH_DATA;
                            state <= ST_RX;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bitcnt == BCW'(BYTE_W-1)) begin
                            sda_pull_low <= 1'b0;
                            state        <= ST_MACK;
                            bitcnt       <= '0;
                        end else begin
                            txb          <= {txb[BYTE_W-2:0], 1'b0};
                            sda_pull_low <= !txb[BYTE_W-2];
                            bitcnt       <= bitcnt + 1'b1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        more <= !sda_in;
                    end else if (scl_fall) begin
                        if (more) begin
                            state        <= ST_TX;
                            txb          <= rd_byte;
                            sda_pull_low <= !rd_byte[BYTE_W-1];
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/eeprom_rd_chk.sv
// Protocol and counter checks for eeprom_rd_target, attached by bind.
module eeprom_rd_chk #(
    parameter int AW = 8,
    parameter int IW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl,
    input logic          sda,
    input logic          drive,
    input logic [AW-1:0] cnt,
    input logic          step,
    input logic          narrow,
    input logic          load,
    input logic [AW-1:0] load_val
);
    // R1
    reset_release_chk: assert property (@(posedge clk)
        !rst_n |=> !drive);

    // R10
    drive_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drive != $past(drive)) |-> !$past(scl));

    // R5
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl && $past(scl) && sda && !$past(sda)) |=> !drive);

    // R3
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val)));

    // R6
    cnt_wide_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !narrow && !load) |=> (cnt == AW'($past(cnt) + 1'b1)));

    // R8
    cnt_narrow_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && narrow && !load) |=>
        ((cnt[IW-1:0] == IW'($past(cnt[IW-1:0]) + 1'b1)) &&
         (cnt[AW-1:IW] == $past(cnt[AW-1:IW]))));
endmodule

bind eeprom_rd_target eeprom_rd_chk #(.AW(MEM_AW), .IW(ID_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl(scl_in), .sda(sda_in),
    .drive(sda_pull_low), .cnt(addr_cnt), .step(cnt_step),
    .narrow(sp_id), .load(cnt_load), .load_val(cnt_load_val)
);

// File: tb/tb_eeprom_rd_target.sv
// Self-checking bench: a two-wire master model driving a vector table of
// transfers, followed by directed reset checks.
module tb_eeprom_rd_target;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 4;
    localparam logic [2:0] CE = 3'b101;
    localparam logic [3:0] MEM_T = 4'b1010;
    localparam logic [3:0] ID_T  = 4'b1011;

    localparam logic [2:0] OP_RMEM  = 3'd0;
    localparam logic [2:0] OP_CMEM  = 3'd1;
    localparam logic [2:0] OP_RID   = 3'd2;
    localparam logic [2:0] OP_CID   = 3'd3;
    localparam logic [2:0] OP_PROBE = 3'd4;
    localparam logic [2:0] OP_BADCE = 3'd5;
    localparam logic [2:0] OP_MDATA = 3'd6;

    typedef struct packed {
        logic [2:0] op;
        logic [7:0] addr;
        logic [3:0] n;
        logic       lock;
        logic       ok;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{OP_RMEM,  8'h10, 4'd3, 1'b0, 1'b1},
        '{OP_CMEM,  8'h00, 4'd2, 1'b0, 1'b1},
        '{OP_RMEM,  8'hFE, 4'd4, 1'b0, 1'b1},
        '{OP_RID,   8'h73, 4'd2, 1'b0, 1'b1},
        '{OP_RID,   8'h0E, 4'd4, 1'b0, 1'b1},
        '{OP_CMEM,  8'h00, 4'd1, 1'b0, 1'b1},
        '{OP_PROBE, 8'h05, 4'd0, 1'b0, 1'b1},
        '{OP_PROBE, 8'h09, 4'd0, 1'b1, 1'b0},
        '{OP_CID,   8'h00, 4'd2, 1'b0, 1'b1},
        '{OP_BADCE, 8'h10, 4'd0, 1'b0, 1'b0},
        '{OP_RID,   8'h80, 4'd0, 1'b0, 1'b0},
        '{OP_MDATA, 8'h20, 4'd0, 1'b0, 1'b0},
        '{OP_CMEM,  8'h00, 4'd1, 1'b0, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic msda = 1'b1;
    logic sda_pull_low;
    logic sda_line;
    logic id_lock = 1'b0;
    logic pre_we = 1'b0;
    logic pre_id = 1'b0;
    logic [7:0] pre_addr = '0;
    logic [7:0] pre_data = '0;

    logic [7:0] memref [256];
    logic [7:0] idref [16];
    logic [7:0] exp_cnt;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    assign sda_line = msda & ~sda_pull_low;

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_rd_target dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
        .sda_pull_low(sda_pull_low), .chip_sel(CE), .id_lock(id_lock),
        .pre_we(pre_we), .pre_id(pre_id), .pre_addr(pre_addr),
        .pre_data(pre_data)
    );

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bit_xfer(input logic d, output logic r);
        msda = d;
        wclk(Q);
        scl = 1'b1;
        wclk(Q);
        r = sda_line;
        wclk(Q);
        scl = 1'b0;
        wclk(Q);
    endtask

    task automatic bus_start();
        msda = 1'b1;
        wclk(Q);
        scl = 1'b1;
        wclk(Q);
        msda = 1'b0;
        wclk(Q);
        scl = 1'b0;
        wclk(Q);
    endtask

    task automatic bus_stop();
        msda = 1'b0;
        wclk(Q);
        scl = 1'b1;
        wclk(Q);
        msda = 1'b1;
        wclk(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ackd);
        logic r;
        for (int i = 7; i >= 0; i--) bit_xfer(b[i], r);
        bit_xfer(1'b1, r);
        ackd = !r;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(1'b1, r);
            b[i] = r;
        end
        bit_xfer(!mack, r);
    endtask

    function automatic logic [7:0] sel(input logic isid, input logic rd);
        return {(isid ? ID_T : MEM_T), CE, rd};
    endfunction

    // Reads n bytes, predicting each from the reference arrays and the model counter.
    task automatic read_n(input logic isid, input int n, input string tag);
        logic [7:0] b;
        logic [7:0] e;
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            if (isid) begin
                e = idref[exp_cnt[3:0]];
                exp_cnt = {exp_cnt[7:4], exp_cnt[3:0] + 4'd1};
            end else begin
                e = memref[exp_cnt];
                exp_cnt = exp_cnt + 8'd1;
            end
            check((i == 0) ? tag : (isid ? "R8 R11" : "R5 R6 R11"), b, e);
        end
    endtask

    task automatic run_vec(input vec_t v);
        logic a;
        logic isid;
        isid = (v.op == OP_RID) || (v.op == OP_CID) || (v.op == OP_PROBE);
        case (v.op)
            OP_RMEM, OP_RID: begin
                bus_start();
                send_byte(sel(isid, 1'b0), a);
                check("R2", {7'd0, a}, 8'd1);
                send_byte(v.addr, a);
                check(isid ? "R7" : "R3", {7'd0, a}, {7'd0, v.ok});
                if (v.ok) begin
                    exp_cnt = isid ? {4'h0, v.addr[3:0]} : v.addr;
                    bus_start();
                    send_byte(sel(isid, 1'b1), a);
                    check("R3", {7'd0, a}, 8'd1);
                    read_n(isid, int'(v.n), isid ? "R7 R11" : "R3 R13 R11");
                end
                bus_stop();
                check("R5", {7'd0, sda_pull_low}, 8'd0);
            end
            OP_CMEM, OP_CID: begin
                bus_start();
                send_byte(sel(isid, 1'b1), a);
                check("R4", {7'd0, a}, 8'd1);
                read_n(isid, int'(v.n), isid ? "R9 R10 R4" : "R4");
                bus_stop();
                check("R5", {7'd0, sda_pull_low}, 8'd0);
            end
            OP_PROBE: begin
                id_lock = v.lock;
                bus_start();
                send_byte(sel(1'b1, 1'b0), a);
                check("R9", {7'd0, a}, 8'd1);
                send_byte(v.addr, a);
                check("R9", {7'd0, a}, 8'd1);
                exp_cnt = {4'h0, v.addr[3:0]};
                send_byte(8'h5A, a);
                check("R9", {7'd0, a}, {7'd0, v.ok});
                bus_start();
                bus_stop();
                check("R10", {7'd0, sda_pull_low}, 8'd0);
                id_lock = 1'b0;
            end
            OP_BADCE: begin
                bus_start();
                send_byte({MEM_T, ~CE, 1'b0}, a);
                check("R2", {7'd0, a}, 8'd0);
                send_byte(v.addr, a);
                check("R2", {7'd0, a}, 8'd0);
                bus_stop();
            end
            default: begin
                bus_start();
                send_byte(sel(1'b0, 1'b0), a);
                check("R12", {7'd0, a}, 8'd1);
                send_byte(v.addr, a);
                check("R12", {7'd0, a}, 8'd1);
                exp_cnt = v.addr;
                send_byte(8'h33, a);
                check("R12", {7'd0, a}, 8'd0);
                bus_stop();
            end
        endcase
    endtask

    initial begin
        logic a;
        for (int i = 0; i < 256; i++) memref[i] = 8'((i * 7) ^ 8'h5C);
        for (int i = 0; i < 16; i++) idref[i] = 8'(8'h90 + i * 3);

        // Reset state
        wclk(5);
        check("R1", {7'd0, sda_pull_low}, 8'd0);
        rst_n = 1'b1;
        wclk(2);

        // Preload both stores (R13)
        for (int i = 0; i < 256; i++) begin
            pre_we = 1'b1; pre_id = 1'b0; pre_addr = 8'(i); pre_data = memref[i];
            wclk(1);
        end
        for (int i = 0; i < 16; i++) begin
            pre_we = 1'b1; pre_id = 1'b1; pre_addr = 8'(i); pre_data = idref[i];
            wclk(1);
        end
        pre_we = 1'b0;
        exp_cnt = 8'h00;
        wclk(4);

        for (int k = 0; k < NV; k++) run_vec(VECS[k]);

        // Reset in the middle of a read releases SDA and clears the counter (R1)
        bus_start();
        send_byte(sel(1'b0, 1'b1), a);
        check("R1", {7'd0, a}, 8'd1);
        rst_n = 1'b0;
        wclk(2);
        check("R1", {7'd0, sda_pull_low}, 8'd0);
        rst_n = 1'b1;
        wclk(2);
        bus_stop();
        exp_cnt = 8'h00;
        bus_start();
        send_byte(sel(1'b0, 1'b1), a);
        check("R1", {7'd0, a}, 8'd1);
        read_n(1'b0, 1, "R1 R4");
        bus_stop();

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule